// File: doc/BRIEF.md
# Branch Condition and Target Unit

This block decides whether a conditional control-flow instruction fires and where it goes. It combines a 4-bit condition code with the processor status flags (zero, negative, overflow, carry) and gives one boolean result. That result serves three users: an absolute branch, a register-relative branch, and a set-on-condition instruction that writes 0 or 1 into a register.

The condition codes form eight pairs. The upper three bits choose a base function of the flags, and the lowest bit inverts it. Absolute targets are a zero-extended word index scaled by four. Relative targets add a sign-extended word offset, scaled by four, to a base register value. A taken branch does not redirect fetch at once: the instruction issued after it always executes as a delay slot. The redirect is reported in the cycle after that slot instruction issues.

The pipeline supplies one instruction at a time with `issue_i`, together with the fields it has already decoded. The block reports the condition result, the branch decision and the computed target combinationally. Only the delay-slot tracking is registered.

Top module: `branch_cond_unit`

## Requirements
- R1: With the low bit as the inverting bit of each pair, the base functions of the upper three bits of `cond_i` are: 001 = C and not Z, 010 = not C, 011 = not Z, 100 = not V, 101 = not N. `flags_i` is {Z, N, V, C} from bit 3 down to bit 0.
- R2: The signed comparisons are: 1100 true when N equals V, 1101 true when N differs from V, 1110 true when Z is clear and N equals V, and 1111 true when Z is set or N differs from V.
- R3: Code 0000 is always true and code 0001 is always false, whatever the flags.
- R4: When `kind_i` = 01 (absolute), `target_o` is `abs_const_i` (23 bits) zero-extended and shifted left by two. Targets are word-aligned and span 0 to 2^25-4.
- R5: When `kind_i` = 10 (relative), `target_o` is `base_i` plus the sign-extended 14-bit `rel_off_i` shifted left by two, taken modulo 2^32.
- R6: `taken_o` is high only when `kind_i` is 01 or 10 and `cond_o` is high. A branch that is not taken leaves `slot_o` low and never produces a redirect.
- R7: `set_val_o` is the condition result zero-extended to 32 bits. For `kind_i` = 11 (set-on-condition) this is the value to be written.
- R8: After a taken branch issues, `slot_o` is high until the next issued instruction. `redirect_o` pulses for exactly one cycle, in the cycle after that delay-slot instruction issues, with `redirect_pc_o` equal to the branch target. Cycles without an issue in between do not consume the slot.
- R9: If the delay-slot instruction is itself a taken branch, the first redirect is dropped. The new target becomes the pending one, and its own delay slot follows.
- R10: During and after reset, `slot_o` and `redirect_o` are low and `redirect_pc_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | An instruction issues this cycle |
| kind_i | input | 2 | 00 other, 01 absolute branch, 10 relative branch, 11 set-on-condition |
| cond_i | input | 4 | Condition code; bit 0 inverts the sense |
| flags_i | input | 4 | {Z, N, V, C} |
| abs_const_i | input | 23 | Absolute word index |
| base_i | input | 32 | Base register value for relative branches |
| rel_off_i | input | 14 | Signed word offset for relative branches |
| cond_o | output | 1 | Condition result |
| taken_o | output | 1 | Branch is taken |
| target_o | output | 32 | Computed branch target |
| set_val_o | output | 32 | Zero-extended condition result |
| slot_o | output | 1 | A redirect is pending; the next issue is a delay slot |
| redirect_o | output | 1 | One-cycle fetch redirect |
| redirect_pc_o | output | 32 | Redirect address |

## Verification
The condition logic is driven with all 16 codes against all 16 flag combinations. This separates a wrong pairing, a missing inversion and a mix-up between the signed comparisons that differ only in how they treat Z. Targets are tried at the edges of the constant ranges: the largest absolute index, a negative offset, the most positive offset, and a base that wraps past zero. These expose a missing sign extension or a wrong scale. The delay-slot sequences insert idle cycles before the slot instruction, use a not-taken branch, and place a taken branch in the slot. This shows whether the redirect waits for the issue, is suppressed when the branch is not taken, and is replaced by a later branch.

// File: rtl/branch_cond_pkg.sv
package branch_cond_pkg;
  typedef enum logic [1:0] {
    KIND_OTHER = 2'b00,
    KIND_ABS   = 2'b01,
    KIND_REL   = 2'b10,
    KIND_SET   = 2'b11
  } br_kind_e;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/cond_eval.sv
module cond_eval
  import branch_cond_pkg::*;
(
  input  logic [3:0] cond_i,
  input  flags_t     flags_i,
  output logic       res_o
);
  logic base;
  logic ge;

  assign ge = (flags_i.n == flags_i.v);

  always_comb begin
    unique case (cond_i[3:1])
      3'b000: base = 1'b1;
      3'b001: base = flags_i.c & ~flags_i.z;
      3'b010: base = ~flags_i.c;
      3'b011: base = ~flags_i.z;
      3'b100: base = ~flags_i.v;
      3'b101: base = ~flags_i.n;
      3'b110: base = ge;
      3'b111: base = ge & ~flags_i.z;
      default: base = 1'b0;
    endcase
  end

  assign res_o = base ^ cond_i[0];

  always_comb begin
    if (cond_i == 4'b0001) assert_never_R3: assert (!res_o);
    if (cond_i == 4'b1111 && flags_i.z) assert_le_on_zero_R2: assert (res_o);
  end
endmodule

// File: rtl/target_gen.sv
module target_gen
  import branch_cond_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ABS_W  = 23,
  parameter int REL_W  = 14
) (
  input  br_kind_e           kind_i,
  input  logic [ABS_W-1:0]   abs_const_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [REL_W-1:0]   rel_off_i,
  output logic [ADDR_W-1:0]  target_o
);
  localparam int ABS_PAD = ADDR_W - ABS_W - 2;
  localparam int REL_PAD = ADDR_W - REL_W - 2;

  logic [ADDR_W-1:0] abs_tgt;
  logic [ADDR_W-1:0] rel_off_ext;

  assign abs_tgt     = {{ABS_PAD{1'b0}}, abs_const_i, 2'b00};
  assign rel_off_ext = {{REL_PAD{rel_off_i[REL_W-1]}}, rel_off_i, 2'b00};

  always_comb begin
    if (kind_i == KIND_REL) target_o = base_i + rel_off_ext;
    else                    target_o = abs_tgt;
  end
endmodule

// File: rtl/slot_tracker.sv
module slot_tracker #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              taken_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic              slot_o,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_pc_o
);
  logic              pend_q;
  logic [ADDR_W-1:0] pend_pc_q;
  logic              redir_q;
  logic [ADDR_W-1:0] redir_pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_pc_q  <= '0;
      redir_q    <= 1'b0;
      redir_pc_q <= '0;
    end else begin
      redir_q <= 1'b0;
      if (issue_i) begin
        // slot instruction consumes pending redirect unless it is a taken branch
        redir_q <= pend_q & ~taken_i;
        if (pend_q && !taken_i) redir_pc_q <= pend_pc_q;
        pend_q <= taken_i;
        if (taken_i) pend_pc_q <= target_i;
      end
    end
  end

  assign slot_o        = pend_q;
  assign redirect_o    = redir_q;
  assign redirect_pc_o = redir_pc_q;

  assert_redirect_after_slot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_q |-> $past(issue_i && pend_q));
  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_q |=> !redir_q);
  assert_slot_branch_replaces_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && pend_q && taken_i) |=> (pend_q && !redir_q && pend_pc_q == $past(target_i)));
  assert_idle_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!issue_i) |=> ($stable(pend_q) && !redir_q));
endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
  import branch_cond_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ABS_W  = 23,
  parameter int REL_W  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [1:0]        kind_i,
  input  logic [3:0]        cond_i,
  input  logic [3:0]        flags_i,
  input  logic [ABS_W-1:0]  abs_const_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [REL_W-1:0]  rel_off_i,
  output logic              cond_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o,
  output logic [ADDR_W-1:0] set_val_o,
  output logic              slot_o,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_pc_o
);
  br_kind_e kind;
  flags_t   flags;
  logic     is_branch;

  assign kind      = br_kind_e'(kind_i);
  assign flags     = flags_t'(flags_i);
  assign is_branch = (kind == KIND_ABS) || (kind == KIND_REL);

  cond_eval u_cond (
    .cond_i  (cond_i),
    .flags_i (flags),
    .res_o   (cond_o)
  );

  target_gen #(.ADDR_W(ADDR_W), .ABS_W(ABS_W), .REL_W(REL_W)) u_tgt (
    .kind_i      (kind),
    .abs_const_i (abs_const_i),
    .base_i      (base_i),
    .rel_off_i   (rel_off_i),
    .target_o    (target_o)
  );

  assign taken_o   = is_branch & cond_o;
  assign set_val_o = {{(ADDR_W-1){1'b0}}, cond_o};

  slot_tracker #(.ADDR_W(ADDR_W)) u_slot (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .issue_i       (issue_i),
    .taken_i       (taken_o),
    .target_i      (target_o),
    .slot_o        (slot_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o)
  );

  assert_taken_needs_branch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (kind_i == 2'b01 || kind_i == 2'b10));
  assert_abs_aligned_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 2'b01) |-> (target_o[1:0] == 2'b00 && target_o < (ADDR_W'(1) << (ABS_W + 2))));
  assert_set_one_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(set_val_o) <= 1);
  assert_reset_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!slot_o && !redirect_o));
endmodule

// File: tb/branch_cond_unit_bench.sv
module branch_cond_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [1:0]  kind = 2'b00;
  logic [3:0]  cond = 4'h0;
  logic [3:0]  flags = 4'h0;
  logic [22:0] abs_c = '0;
  logic [31:0] base = '0;
  logic [13:0] roff = '0;
  logic        cond_o, taken_o, slot_o, redirect_o;
  logic [31:0] target_o, set_val_o, redirect_pc_o;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  branch_cond_unit u_branch_cond_unit (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .kind_i(kind), .cond_i(cond),
    .flags_i(flags), .abs_const_i(abs_c), .base_i(base), .rel_off_i(roff),
    .cond_o(cond_o), .taken_o(taken_o), .target_o(target_o), .set_val_o(set_val_o),
    .slot_o(slot_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic ref_cond(input logic [3:0] c, input logic [3:0] f);
    logic z, n, v, cy;
    {z, n, v, cy} = f;
    case (c)
      4'd0: return 1'b1;
      4'd1: return 1'b0;
      4'd2: return cy && !z;
      4'd3: return !cy || z;
      4'd4: return !cy;
      4'd5: return cy;
      4'd6: return !z;
      4'd7: return z;
      4'd8: return !v;
      4'd9: return v;
      4'd10: return !n;
      4'd11: return n;
      4'd12: return n == v;
      4'd13: return n != v;
      4'd14: return !z && (n == v);
      default: return z || (n != v);
    endcase
  endfunction

  task automatic test_reset();
    chk("R10 slot", {31'b0, slot_o}, 32'd0);
    chk("R10 redirect", {31'b0, redirect_o}, 32'd0);
    chk("R10 pc", redirect_pc_o, 32'd0);
  endtask

  task automatic test_conditions();
    kind = 2'b11;
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        cond = 4'(c);
        flags = 4'(f);
        #1;
        if (c < 2)       chk("R3 cond", {31'b0, cond_o}, {31'b0, ref_cond(cond, flags)});
        else if (c < 12) chk("R1 cond", {31'b0, cond_o}, {31'b0, ref_cond(cond, flags)});
        else             chk("R2 cond", {31'b0, cond_o}, {31'b0, ref_cond(cond, flags)});
        chk("R7 set value", set_val_o, {31'b0, ref_cond(cond, flags)});
        chk("R6 set not taken", {31'b0, taken_o}, 32'd0);
      end
    end
    @(negedge clk);
  endtask

  task automatic test_absolute();
    kind = 2'b01; cond = 4'h0; flags = 4'h0;
    abs_c = 23'h7FFFFF; #1;
    chk("R4 max target", target_o, 32'h01FF_FFFC);
    chk("R6 taken abs", {31'b0, taken_o}, 32'd1);
    abs_c = 23'd1; #1;
    chk("R4 one word", target_o, 32'h4);
    cond = 4'h1; #1;
    chk("R6 not taken", {31'b0, taken_o}, 32'd0);
    kind = 2'b00; cond = 4'h0; #1;
    chk("R6 other kind", {31'b0, taken_o}, 32'd0);
    @(negedge clk);
  endtask

  task automatic test_relative();
    kind = 2'b10; cond = 4'h0;
    base = 32'h1000; roff = 14'h3FFF; #1;
    chk("R5 negative offset", target_o, 32'h0000_0FFC);
    roff = 14'h1FFF; #1;
    chk("R5 max positive", target_o, 32'h0000_8FFC);
    roff = 14'h2000; #1;
    chk("R5 max negative", target_o, 32'hFFFF_9000);
    base = 32'hFFFF_FFFC; roff = 14'd1; #1;
    chk("R5 wrap", target_o, 32'h0);
    @(negedge clk);
  endtask

  task automatic test_delay_slot();
    issue = 1'b1; kind = 2'b01; cond = 4'h0; abs_c = 23'h10;
    step();
    issue = 1'b0; kind = 2'b00;
    chk("R8 slot set", {31'b0, slot_o}, 32'd1);
    chk("R8 no early redirect", {31'b0, redirect_o}, 32'd0);
    step();
    step();
    chk("R8 idle keeps slot", {31'b0, slot_o}, 32'd1);
    chk("R8 idle no redirect", {31'b0, redirect_o}, 32'd0);
    issue = 1'b1;
    step();
    issue = 1'b0;
    chk("R8 redirect pulse", {31'b0, redirect_o}, 32'd1);
    chk("R8 redirect pc", redirect_pc_o, 32'h40);
    chk("R8 slot cleared", {31'b0, slot_o}, 32'd0);
    step();
    chk("R8 pulse ends", {31'b0, redirect_o}, 32'd0);
  endtask

  task automatic test_not_taken();
    issue = 1'b1; kind = 2'b01; cond = 4'h1; abs_c = 23'h20;
    step();
    chk("R6 no slot", {31'b0, slot_o}, 32'd0);
    kind = 2'b00;
    step();
    issue = 1'b0;
    chk("R6 no redirect", {31'b0, redirect_o}, 32'd0);
    step();
  endtask

  task automatic test_branch_in_slot();
    issue = 1'b1; kind = 2'b01; cond = 4'h7; flags = 4'b1000; abs_c = 23'h10;
    step();
    kind = 2'b10; cond = 4'h6; flags = 4'b0000; base = 32'h200; roff = 14'd2;
    step();
    chk("R9 first dropped", {31'b0, redirect_o}, 32'd0);
    chk("R9 still pending", {31'b0, slot_o}, 32'd1);
    kind = 2'b00;
    step();
    issue = 1'b0;
    chk("R9 redirect", {31'b0, redirect_o}, 32'd1);
    chk("R9 new target", redirect_pc_o, 32'h208);
    step();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_conditions();
    test_absolute();
    test_relative();
    test_delay_slot();
    test_not_taken();
    test_branch_in_slot();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule